// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the control-memory address of each microinstruction. It holds a 12-bit program counter, and every clock cycle it applies one decoded sequencing command to that counter. The command may step to the next word, step past an inline literal, jump to an absolute address, or branch by a signed offset when a selected condition flag is set. It may also call a subroutine, return from one, or add a bus value to the counter for table dispatch. Subroutine return addresses are kept in an internal 15-entry LIFO.

The surrounding decoder supplies the command, the condition selector, the jump field and the bus value. The flags come from the data path. The output `pc_o` is the address fetched for the current cycle. `depth_o` shows how many return addresses are stored. `err_o` latches any call made into a full stack and any return made from an empty one.

Top module: `useq_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `pc_o` is 0, `depth_o` is 0 and `err_o` is 0 until the first command takes effect.
- R2: Command 0 (step) loads `pc_o`+1 at the next clock edge. Command 1 (literal step) loads `pc_o`+2, skipping the inline literal word.
- R3: Command 2 (absolute jump) loads `jump_field_i` into the PC.
- R4: Command 3 (branch) tests the flag picked by `cond_sel_i`: 0 always, 1 carry=`flags_i[0]`, 2 overflow=`flags_i[1]`, 3 zero=`flags_i[2]`, 4 negative=`flags_i[3]`, 5 interrupt=`flags_i[4]`, 6 and 7 never. When the test holds, the PC becomes `pc_o` plus the sign-extended `jump_field_i[10:0]`. Otherwise the PC becomes `pc_o`+1.
- R5: Command 4 (call) stores `pc_o`+1 as a return address, raises `depth_o` by one and loads `jump_field_i` into the PC.
- R6: Command 5 (return) loads the most recently stored return address into the PC and lowers `depth_o` by one. Returns are served last-in first-out across up to 15 nested calls, and `depth_o` never exceeds 15.
- R7: A call made while `depth_o` is 15, or a return made while `depth_o` is 0, sets `err_o`. `err_o` then stays set until reset, and the stored entries and depth are left unchanged. A call that overflows still jumps to `jump_field_i`. A return that underflows advances to `pc_o`+1.
- R8: Command 6 (dispatch) loads `pc_o` + `bus_i[11:0]`. Command 7 (skip) loads `pc_o` + 1 + `bus_i[11:0]`. `bus_i[15:12]` is ignored.
- R9: All address arithmetic wraps modulo 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Sequencing command |
| cond_sel_i | input | 3 | Branch condition selector |
| flags_i | input | 5 | {interrupt, negative, zero, overflow, carry} |
| jump_field_i | input | 12 | Absolute target or relative offset (low 11 bits) |
| bus_i | input | 16 | Bus value for dispatch and skip |
| pc_o | output | 12 | Current control-memory address |
| depth_o | output | 4 | Number of stored return addresses |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Directed sequences try each condition selector with its flag set and with it clear, so that a wrong flag-to-selector mapping shows up as a wrong taken/not-taken decision. They also try negative and forward offsets, a jump to the last address followed by steps, and bus values with high bits set. Separately, nested calls are made to full depth and unwound, which checks the LIFO order entry by entry. One extra call and one return from empty then check that the error latches and that the stack contents survive. A long run of random commands with mixed flags and fields compares every cycle against a bench model; this exposes interactions such as a call directly after a dispatch.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    SEQ_NEXT   = 3'd0,
    SEQ_IMM    = 3'd1,
    SEQ_JUMP   = 3'd2,
    SEQ_BRANCH = 3'd3,
    SEQ_CALL   = 3'd4,
    SEQ_RET    = 3'd5,
    SEQ_DISP   = 3'd6,
    SEQ_SKIP   = 3'd7
  } seq_cmd_e;

  typedef enum logic [2:0] {
    CND_ALWAYS = 3'd0,
    CND_CARRY  = 3'd1,
    CND_OVF    = 3'd2,
    CND_ZERO   = 3'd3,
    CND_NEG    = 3'd4,
    CND_IRQ    = 3'd5,
    CND_NONE6  = 3'd6,
    CND_NONE7  = 3'd7
  } cond_sel_e;

  localparam int unsigned FLAG_N = 5;
endpackage

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  logic [2:0]        cond_sel_i,
  input  logic [FLAG_N-1:0] flags_i,
  output logic              take_o
);
  cond_sel_e sel;
  assign sel = cond_sel_e'(cond_sel_i);

  always_comb begin
    unique case (sel)
      CND_ALWAYS: take_o = 1'b1;
      CND_CARRY:  take_o = flags_i[0];
      CND_OVF:    take_o = flags_i[1];
      CND_ZERO:   take_o = flags_i[2];
      CND_NEG:    take_o = flags_i[3];
      CND_IRQ:    take_o = flags_i[4];
      default:    take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 15,
  localparam int unsigned DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  push_data_i,
  output logic [W-1:0]  top_o,
  output logic [DW-1:0] depth_o,
  output logic          empty_o,
  output logic          fault_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [DW-1:0] sp_q;
  logic          full, do_push, do_pop;
  logic [DW-1:0] top_idx;

  assign full    = (sp_q == DW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign fault_o = (push_i && full) || (pop_i && empty_o);
  assign top_idx = sp_q - 1'b1;
  assign depth_o = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= '0;
    else if (do_push) sp_q <= sp_q + 1'b1;
    else if (do_pop)  sp_q <= sp_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (do_push && sp_q == DW'(g))   mem_q[g] <= push_data_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!empty_o && top_idx == DW'(i)) top_o = mem_q[i];
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= DW'(DEPTH)); // R6
  AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full) |=> sp_q == $past(sp_q) + 1'b1); // R5
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) |=> $stable(sp_q)); // R7
  AST_UNF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(sp_q)); // R7
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int unsigned PC_W  = 12,
  parameter int unsigned OFF_W = 11,
  parameter int unsigned BUS_W = 16
) (
  input  logic [2:0]       cmd_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  jump_field_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             take_i,
  input  logic [PC_W-1:0]  stack_top_i,
  input  logic             stack_empty_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             push_o,
  output logic             pop_o,
  output logic [PC_W-1:0]  push_data_o
);
  seq_cmd_e        cmd;
  logic [PC_W-1:0] pc_inc, offset_ext, bus_lo;

  assign cmd        = seq_cmd_e'(cmd_i);
  assign pc_inc     = pc_i + PC_W'(1);
  assign offset_ext = {{(PC_W-OFF_W){jump_field_i[OFF_W-1]}}, jump_field_i[OFF_W-1:0]};
  assign bus_lo     = bus_i[PC_W-1:0];
  assign push_data_o = pc_inc;

  always_comb begin
    push_o    = 1'b0;
    pop_o     = 1'b0;
    next_pc_o = pc_inc;
    unique case (cmd)
      SEQ_NEXT:   next_pc_o = pc_inc;
      SEQ_IMM:    next_pc_o = pc_i + PC_W'(2);
      SEQ_JUMP:   next_pc_o = jump_field_i;
      SEQ_BRANCH: next_pc_o = take_i ? pc_i + offset_ext : pc_inc;
      SEQ_CALL: begin
        push_o    = 1'b1;
        next_pc_o = jump_field_i;
      end
      SEQ_RET: begin
        pop_o     = 1'b1;
        next_pc_o = stack_empty_i ? pc_inc : stack_top_i;
      end
      SEQ_DISP:   next_pc_o = pc_i + bus_lo;
      SEQ_SKIP:   next_pc_o = pc_inc + bus_lo;
      default:    next_pc_o = pc_inc;
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int unsigned PC_W        = 12,
  parameter int unsigned OFF_W       = 11,
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned STACK_DEPTH = 15,
  localparam int unsigned DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         cmd_i,
  input  logic [2:0]         cond_sel_i,
  input  logic [FLAG_N-1:0]  flags_i,
  input  logic [PC_W-1:0]    jump_field_i,
  input  logic [BUS_W-1:0]   bus_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               err_o
);
  logic [PC_W-1:0] pc_q, next_pc, stk_top, push_data;
  logic            take, push, pop, stk_empty, stk_fault, err_q;

  useq_cond u_cond (
    .cond_sel_i (cond_sel_i),
    .flags_i    (flags_i),
    .take_o     (take)
  );

  useq_next_addr #(.PC_W(PC_W), .OFF_W(OFF_W), .BUS_W(BUS_W)) u_next (
    .cmd_i         (cmd_i),
    .pc_i          (pc_q),
    .jump_field_i  (jump_field_i),
    .bus_i         (bus_i),
    .take_i        (take),
    .stack_top_i   (stk_top),
    .stack_empty_i (stk_empty),
    .next_pc_o     (next_pc),
    .push_o        (push),
    .pop_o         (pop),
    .push_data_o   (push_data)
  );

  useq_ret_stack #(.W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (push_data),
    .top_o       (stk_top),
    .depth_o     (depth_o),
    .empty_o     (stk_empty),
    .fault_o     (stk_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= next_pc;
      err_q <= err_q | stk_fault;
    end
  end

  assign pc_o  = pc_q;
  assign err_o = err_q;

  AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == SEQ_NEXT) |=> pc_o == $past(pc_o) + PC_W'(1)); // R2
  AST_JUMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == SEQ_JUMP) |=> pc_o == $past(jump_field_i)); // R3
  AST_RET_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == SEQ_RET && !stk_empty) |=> pc_o == $past(stk_top)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [2:0]  cmd, csel;
  logic [4:0]  flags;
  logic [11:0] jf;
  logic [15:0] bus;
  logic [11:0] pc_o;
  logic [3:0]  depth_o;
  logic        err_o;

  int unsigned n_chk = 0, n_bad = 0;
  logic [11:0] m_pc;
  logic [11:0] m_stk [15];
  int          m_dep;
  logic        m_err;

  always #5 clk = ~clk;

  useq_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .cond_sel_i(csel),
    .flags_i(flags), .jump_field_i(jf), .bus_i(bus),
    .pc_o(pc_o), .depth_o(depth_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic cond_ok(input logic [2:0] s, input logic [4:0] f);
    case (s)
      3'd0: return 1'b1;
      3'd1: return f[0];
      3'd2: return f[1];
      3'd3: return f[2];
      3'd4: return f[3];
      3'd5: return f[4];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    m_pc = '0; m_dep = 0; m_err = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cmd = '0; csel = '0; flags = '0; jf = '0; bus = '0;
    @(posedge clk); @(negedge clk);
    chk("R1 pc", pc_o, 0); chk("R1 depth", depth_o, 0); chk("R1 err", err_o, 0);
    rst_ni = 1'b1;
    model_reset();
    @(posedge clk); @(negedge clk);
    chk("R1 pc after release", pc_o, 1);
    m_pc = 12'd1;
  endtask

  // drives at negedge, checks at next negedge
  task automatic step(input logic [2:0] c, input logic [2:0] s, input logic [4:0] f,
                      input logic [11:0] j, input logic [15:0] b);
    logic [11:0] sx;
    cmd = c; csel = s; flags = f; jf = j; bus = b;
    sx = {j[10], j[10:0]};
    case (c)
      3'd0: m_pc = m_pc + 12'd1;
      3'd1: m_pc = m_pc + 12'd2;
      3'd2: m_pc = j;
      3'd3: m_pc = cond_ok(s, f) ? m_pc + sx : m_pc + 12'd1;
      3'd4: begin
        if (m_dep == 15) m_err = 1'b1;
        else begin m_stk[m_dep] = m_pc + 12'd1; m_dep++; end
        m_pc = j;
      end
      3'd5: begin
        if (m_dep == 0) begin m_err = 1'b1; m_pc = m_pc + 12'd1; end
        else begin m_dep--; m_pc = m_stk[m_dep]; end
      end
      3'd6: m_pc = m_pc + b[11:0];
      default: m_pc = m_pc + 12'd1 + b[11:0];
    endcase
    @(posedge clk); @(negedge clk);
    chk({tag_of(c), " R9 pc"}, pc_o, m_pc);
    chk({tag_of(c), " R6 depth"}, depth_o, m_dep);
    chk({tag_of(c), " R7 err"}, err_o, m_err);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0;
    @(negedge clk);
    do_reset();
    // R2 step and literal step
    step(3'd0, 0, 0, 0, 0);
    step(3'd1, 0, 0, 0, 0);
    // R3 / R9 jump to last address, then wrap
    step(3'd2, 0, 0, 12'hFFF, 0);
    step(3'd0, 0, 0, 0, 0);
    step(3'd1, 0, 0, 0, 0);
    // R4 each selector with flag set and clear
    for (int s = 0; s < 8; s++) begin
      step(3'd3, 3'(s), 5'h1F, 12'h010, 0);
      step(3'd3, 3'(s), 5'h00, 12'h010, 0);
    end
    step(3'd3, 3'd2, 5'b00010, 12'h7F0, 0); // R4 negative offset
    step(3'd2, 0, 0, 12'h003, 0);
    step(3'd3, 3'd0, 0, 12'h7F8, 0);        // R9 wraps below zero
    // R8 dispatch/skip with upper bus bits set
    step(3'd6, 0, 0, 0, 16'hF123);
    step(3'd7, 0, 0, 0, 16'hA0FF);
    // R5/R6 full nesting, then unwind in LIFO order
    for (int k = 0; k < 15; k++) step(3'd4, 0, 0, 12'(k * 37 + 5), 0);
    chk("R6 full depth", depth_o, 15);
    step(3'd4, 0, 0, 12'h777, 0);          // R7 overflow
    chk("R7 overflow err", err_o, 1);
    for (int k = 0; k < 15; k++) step(3'd5, 0, 0, 0, 0);
    step(3'd5, 0, 0, 0, 0);                // R7 underflow, sticky
    step(3'd0, 0, 0, 0, 0);
    chk("R7 still set", err_o, 1);
    // R7 underflow from fresh reset
    do_reset();
    step(3'd5, 0, 0, 0, 0);
    chk("R7 underflow depth", depth_o, 0);
    // random mix
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      if (n % 1000 == 999) do_reset();
      step(c, 3'($urandom), 5'($urandom), 12'($urandom), 16'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule